// File: doc/BRIEF.md
# I2C Bit-Level Master Byte Engine

This block drives a two-wire I2C bus as a master, one bus primitive at a time, from a fast system clock. Every SCL and SDA transition falls on a grid of quarter periods. A quarter lasts a programmable number of system clocks, so one full SCL period is four quarters. The engine drives SCL directly. SDA is handled as an open-drain line: the block only pulls it low or lets it go, and it reads the line back through a two-flop synchronizer.

A controller hands over one command while the engine is idle. The five commands are bus recovery, START, STOP, write one byte, and read one byte with a chosen acknowledge level. The engine raises `busy` for the whole command. It then pulses `done` for one clock, at which point `rd_data` and `nack` hold the results. Recovery clocks nine pulses with SDA released and then issues a STOP, which frees a slave that is holding SDA low.

The state machine has eight states. S_IDLE waits for a command. S_RECOV runs the nine recovery pulses. S_START and S_STOP form the bus conditions. S_WBIT shifts out a data bit. S_WACK samples the slave's acknowledge. S_RBIT samples a data bit. S_RACK sends the master's acknowledge. The transitions are:
- S_IDLE goes to S_RECOV, S_START, S_STOP, S_WBIT or S_RBIT on an accepted command.
- S_RECOV goes to S_STOP after its ninth pulse.
- S_WBIT goes to S_WACK after its eighth bit.
- S_RBIT goes to S_RACK after its eighth bit.
- S_START, S_STOP, S_WACK and S_RACK return to S_IDLE on their last quarter.

Top module: `i2c_byte_engine`

## Requirements
- R1: Reset behaviour.
  - After reset, `busy` and `done` are 0, `scl_o` is 1 and `sda_rel_o` is 1.
  - `sda_rel_o` = 1 means SDA is released, and `sda_rel_o` = 0 means SDA is pulled low.
- R2: Timing of a command.
  - A quarter lasts `qtr_len` clocks, and a value of 0 counts as 1.
  - A command with opcode 1 (recover), 2 (start), 3 (stop), 4 (write) or 5 (read) takes 40, 4, 4, 37 or 29 quarters respectively.
  - `done` is high for exactly one clock, and `busy` falls in that same cycle.
- R3: START releases SDA, raises SCL, then pulls SDA low while SCL is high. It ends with SCL high and SDA low.
- R4: STOP lowers SCL and pulls SDA low, raises SCL, then releases SDA while SCL is high. It ends with both lines high.
- R5: Write sends the 8 bits MSB first. SDA changes only while SCL is low and holds its value at each SCL rising edge.
- R6: After the 8th written bit, SDA is released for a 9th clock. The SDA level sampled two quarters after that clock rises appears on `nack` (0 = acknowledged).
- R7: Read releases SDA for all 8 data clocks and assembles the bits sampled one quarter after each SCL rise into `rd_data`, MSB first.
- R8: After a read, SDA holds `cmd_ack_lvl` (0 = ACK, 1 = NACK) at the 9th SCL rising edge.
- R9: Recovery gives 9 SCL pulses with SDA released, then a STOP. That makes 10 SCL rising edges in total, and the command ends with SDA released.
- R10: `cmd_valid` is ignored while `busy` is high, and opcodes 0, 6 and 7 are ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qtr_len | input | QW | Clocks per quarter period; hold stable while busy |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Opcode: 1 recover, 2 start, 3 stop, 4 write, 5 read |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack_lvl | input | 1 | Acknowledge level to send after a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock pulse at command end |
| rd_data | output | 8 | Byte assembled by the last read |
| nack | output | 1 | Acknowledge level sampled after the last write |
| scl_o | output | 1 | SCL level driven onto the bus |
| sda_rel_o | output | 1 | 1 releases SDA, 0 pulls it low |
| sda_i | input | 1 | SDA line level as seen on the bus |

## Verification
The command is accepted on the clock edge where `cmd_valid` is seen while idle. From that edge, `done` is due exactly quarters × `qtr_len` clocks later, where quarters is the count for the opcode in R2. The bench counts clocks from the accept edge and compares the count with a function of the opcode and quarter length. It then reads `rd_data`, `nack` and the line levels in the same cycle that `done` is seen, away from the clock edge. The bus-level results are not timed by clock count. They are checked at each SCL rising edge: the SDA level there, the number of rising edges, and the START and STOP conditions seen on the wired line. The slave model in the bench changes SDA only just after SCL falls, so every sample point finds SDA already settled through the synchronizer.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RECOV, S_START, S_STOP, S_WBIT, S_WACK, S_RBIT, S_RACK
    } state_e;

    localparam int BYTE_BITS    = 8;
    localparam int RECOV_PULSES = 9;
    localparam int CNT_W        = $clog2(RECOV_PULSES + 1);
endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
    parameter int QW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [QW-1:0] len,
    output logic          tick
);
    logic [QW-1:0] cnt;
    logic [QW-1:0] lim;

    assign lim  = (len == '0) ? '0 : len - 1'b1;
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(len)) |-> (cnt <= lim));
endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int QW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [QW-1:0]        qtr_len,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BYTE_BITS-1:0] cmd_wdata,
    input  logic                 cmd_ack_lvl,
    output logic                 busy,
    output logic                 done,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 nack,
    output logic                 scl_o,
    output logic                 sda_rel_o,
    input  logic                 sda_i
);
    localparam int LAST_BIT = BYTE_BITS - 1;

    state_e               st, st_n;
    logic [2:0]           q, q_n;
    logic [CNT_W-1:0]     bc, bc_n;
    logic                 fin, accept, op_ok, tick, sda_s;
    logic [BYTE_BITS-1:0] wsh, rsh;
    logic                 ackl;

    assign busy    = (st != S_IDLE);
    assign rd_data = rsh;

    always_comb begin
        unique case (cmd_op)
            OP_RECOVER, OP_START, OP_STOP, OP_WRITE, OP_READ: op_ok = 1'b1;
            default:                                          op_ok = 1'b0;
        endcase
    end

    assign accept = cmd_valid && !busy && op_ok;

    i2c_qtr_timer #(.QW(QW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .run  (busy),
        .len  (qtr_len),
        .tick (tick)
    );

    i2c_sda_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_i),
        .q    (sda_s)
    );

    // next state, quarter index and bit counter
    always_comb begin
        st_n = st;
        q_n  = q;
        bc_n = bc;
        fin  = 1'b0;
        if (accept) begin
            q_n  = '0;
            bc_n = '0;
            unique case (cmd_op)
                OP_RECOVER: st_n = S_RECOV;
                OP_START:   st_n = S_START;
                OP_STOP:    st_n = S_STOP;
                OP_WRITE:   st_n = S_WBIT;
                default:    st_n = S_RBIT;
            endcase
        end else if (busy && tick) begin
            q_n = q + 3'd1;
            unique case (st)
                S_RECOV: if (q == 3'd3) begin
                    q_n = '0;
                    if (bc == CNT_W'(RECOV_PULSES - 1)) begin
                        st_n = S_STOP;
                        bc_n = '0;
                    end else bc_n = bc + 1'b1;
                end
                S_START, S_STOP: if (q == 3'd3) fin = 1'b1;
                S_WBIT: if (q == 3'd3) begin
                    q_n = '0;
                    if (bc == CNT_W'(LAST_BIT)) begin
                        st_n = S_WACK;
                        bc_n = '0;
                    end else bc_n = bc + 1'b1;
                end
                S_RBIT: if (q == 3'd2) begin
                    q_n = '0;
                    if (bc == CNT_W'(LAST_BIT)) begin
                        st_n = S_RACK;
                        bc_n = '0;
                    end else bc_n = bc + 1'b1;
                end
                S_WACK, S_RACK: if (q == 3'd4) fin = 1'b1;
                default: ;
            endcase
            if (fin) begin
                st_n = S_IDLE;
                q_n  = '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
            q  <= '0;
            bc <= '0;
        end else begin
            st <= st_n;
            q  <= q_n;
            bc <= bc_n;
        end
    end

    // outputs: line levels set on entry to each quarter, samples at quarter end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o     <= 1'b1;
            sda_rel_o <= 1'b1;
            done      <= 1'b0;
            nack      <= 1'b0;
            rsh       <= '0;
            wsh       <= '0;
            ackl      <= 1'b1;
        end else begin
            done <= fin;
            if (accept) begin
                wsh  <= cmd_wdata;
                ackl <= cmd_ack_lvl;
                if (cmd_op == OP_READ) rsh <= '0;
            end
            if (tick && st == S_WBIT && q == 3'd3) wsh <= wsh << 1;
            if (tick && st == S_WACK && q == 3'd3) nack <= sda_s;
            if (tick && st == S_RBIT && q == 3'd1) rsh <= {rsh[BYTE_BITS-2:0], sda_s};
            if (accept || (busy && tick && !fin)) begin
                unique case (st_n)
                    S_RECOV: begin
                        sda_rel_o <= 1'b1;
                        if (q_n == 3'd0) scl_o <= 1'b0;
                        if (q_n == 3'd2) scl_o <= 1'b1;
                    end
                    S_START: begin
                        if (q_n == 3'd1) sda_rel_o <= 1'b1;
                        if (q_n == 3'd2) scl_o     <= 1'b1;
                        if (q_n == 3'd3) sda_rel_o <= 1'b0;
                    end
                    S_STOP: begin
                        if (q_n == 3'd0) scl_o     <= 1'b0;
                        if (q_n == 3'd1) sda_rel_o <= 1'b0;
                        if (q_n == 3'd2) scl_o     <= 1'b1;
                        if (q_n == 3'd3) sda_rel_o <= 1'b1;
                    end
                    S_WBIT: begin
                        if (q_n == 3'd0) scl_o     <= 1'b0;
                        if (q_n == 3'd1) sda_rel_o <= wsh[BYTE_BITS-1];
                        if (q_n == 3'd2) scl_o     <= 1'b1;
                    end
                    S_WACK, S_RACK: begin
                        if (q_n == 3'd0) scl_o     <= 1'b0;
                        if (q_n == 3'd1) sda_rel_o <= (st_n == S_WACK) ? 1'b1 : ackl;
                        if (q_n == 3'd2) scl_o     <= 1'b1;
                        if (q_n == 3'd4) scl_o     <= 1'b0;
                    end
                    S_RBIT: begin
                        sda_rel_o <= 1'b1;
                        if (q_n == 3'd0) scl_o <= 1'b0;
                        if (q_n == 3'd1) scl_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    scl_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(scl_o) |-> $past(tick || accept));
    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RBIT) |-> sda_rel_o);
    // R9
    recov_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RECOV) |-> sda_rel_o);
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(st));
endmodule

// File: tb/tb_i2c_byte_engine.sv
`timescale 1ns/1ps
module tb_i2c_byte_engine;
    localparam int QW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] qtr_len = 12'd3;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [7:0]    cmd_wdata = 8'h00;
    logic          cmd_ack_lvl = 1'b1;
    logic          busy, done, nack, scl_o, sda_rel_o, sda_i;
    logic [7:0]    rd_data;

    logic          slave_n = 1'b1;
    int            mode = 0;
    logic [7:0]    slave_byte = 8'h00;
    logic          slave_ack = 1'b0;
    int            rises = 0, starts = 0, stops = 0;
    logic [15:0]   rhist = '0;
    logic          p_scl = 1'b1, p_sda = 1'b1;
    int            n_chk = 0, n_fail = 0, cyc = 0;

    assign sda_i = sda_rel_o & slave_n;

    i2c_byte_engine #(.QW(QW)) dut (
        .clk(clk), .rst_n(rst_n), .qtr_len(qtr_len), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl),
        .busy(busy), .done(done), .rd_data(rd_data), .nack(nack),
        .scl_o(scl_o), .sda_rel_o(sda_rel_o), .sda_i(sda_i)
    );

    always #2.5 clk = ~clk;

    // bus monitor and slave model, away from the active edge
    always @(negedge clk) begin
        if (scl_o && !p_scl) begin
            rises = rises + 1;
            rhist = {rhist[14:0], sda_rel_o};
        end
        if (scl_o && p_scl && p_sda && !sda_i) starts = starts + 1;
        if (scl_o && p_scl && !p_sda && sda_i) stops = stops + 1;
        if (!scl_o && p_scl) begin
            if (mode == 1) slave_n = (rises == 8) ? slave_ack : 1'b1;
            else if (mode == 2) slave_n = (rises < 8) ? slave_byte[7 - rises] : 1'b1;
        end
        p_scl = scl_o;
        p_sda = sda_i;
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int quarters(input int op);
        case (op)
            1: return 40;
            2: return 4;
            3: return 4;
            4: return 37;
            5: return 29;
            default: return 0;
        endcase
    endfunction

    function automatic int eff_len(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    // issue a command, optionally poke a second strobe while busy; returns clocks to done
    task automatic run_cmd(input int op, input logic [7:0] wd, input logic ackv,
                           input int poke, output int clocks);
        int c;
        @(posedge clk); #1;
        rises = 0;
        rhist = '0;
        if (op == 4) begin mode = 1; slave_n = 1'b1; end
        else if (op == 5) begin mode = 2; slave_n = slave_byte[7]; end
        else begin mode = 0; slave_n = 1'b1; end
        cmd_op = 3'(op); cmd_wdata = wd; cmd_ack_lvl = ackv; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        c = 0;
        while (!done && c < 20000) begin
            @(posedge clk); #1;
            c = c + 1;
            if (poke > 0 && c == poke) begin cmd_valid = 1'b1; cmd_op = 3'd3; end
            else cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        clocks = c;
    endtask

    task automatic check_done_edge();
        @(posedge clk); #1;
        chk(!done && !busy, "R2 done one clock", {done, busy}, 0);
    endtask

    int clocks, ql, sts, sps;
    logic [7:0] d;
    logic a;

    initial begin
        void'($urandom(32'h1BADB002));
        #12;
        chk(!busy && !done && scl_o && sda_rel_o, "R1 reset state",
            {busy, done, scl_o, sda_rel_o}, 4'b0011);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: invalid opcodes are ignored
        cmd_op = 3'd7; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_op = 3'd0;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        chk(!busy && scl_o && sda_rel_o, "R10 bad opcode ignored", busy, 0);

        // R9 recovery
        qtr_len = 12'd3; slave_byte = 8'h00;
        sps = stops;
        run_cmd(1, 8'h00, 1'b1, 0, clocks);
        chk(clocks == 40 * 3, "R2 recover duration", clocks, 120);
        chk(rises == 10, "R9 recover rising edges", rises, 10);
        chk(rhist[9:0] == 10'b1111111110, "R9 SDA released over pulses", rhist[9:0], 10'h3FE);
        chk(stops == sps + 1 && sda_rel_o && scl_o, "R9 trailing stop", stops - sps, 1);
        check_done_edge();

        // R3 start
        sts = starts;
        run_cmd(2, 8'h00, 1'b1, 0, clocks);
        chk(clocks == 4 * 3, "R2 start duration", clocks, 12);
        chk(starts == sts + 1 && scl_o && !sda_rel_o, "R3 start condition", starts - sts, 1);

        // R5/R6 write acked
        slave_ack = 1'b0;
        run_cmd(4, 8'hA5, 1'b1, 0, clocks);
        chk(clocks == 37 * 3, "R2 write duration", clocks, 111);
        chk(rhist[8:0] == {8'hA5, 1'b1}, "R5 write bits MSB first", rhist[8:0], {8'hA5, 1'b1});
        chk(nack == 1'b0, "R6 ack sampled", nack, 0);

        // R6 write nacked, with strobe while busy (R10)
        slave_ack = 1'b1;
        sps = stops;
        run_cmd(4, 8'h3C, 1'b1, 20, clocks);
        chk(clocks == 37 * 3, "R10 busy strobe ignored duration", clocks, 111);
        chk(stops == sps && rhist[8:0] == {8'h3C, 1'b1}, "R10 busy strobe no effect",
            rhist[8:0], {8'h3C, 1'b1});
        chk(nack == 1'b1, "R6 nack sampled", nack, 1);

        // R7/R8 reads
        slave_byte = 8'h96;
        run_cmd(5, 8'h00, 1'b0, 0, clocks);
        chk(clocks == 29 * 3, "R2 read duration", clocks, 87);
        chk(rd_data == 8'h96, "R7 read data", rd_data, 8'h96);
        chk(rhist[8:0] == 9'h1FE, "R8 ack level 0 sent, R7 released", rhist[8:0], 9'h1FE);
        slave_byte = 8'h5A;
        run_cmd(5, 8'h00, 1'b1, 0, clocks);
        chk(rd_data == 8'h5A, "R7 read data", rd_data, 8'h5A);
        chk(rhist[8:0] == 9'h1FF, "R8 nack level sent", rhist[8:0], 9'h1FF);

        // R4 stop
        sps = stops;
        run_cmd(3, 8'h00, 1'b1, 0, clocks);
        chk(clocks == 4 * 3, "R2 stop duration", clocks, 12);
        chk(stops == sps + 1 && scl_o && sda_rel_o, "R4 stop condition", stops - sps, 1);

        // R2 zero quarter length counts as one
        qtr_len = 12'd0;
        run_cmd(2, 8'h00, 1'b1, 0, clocks);
        chk(clocks == 4, "R2 zero quarter length", clocks, 4);
        check_done_edge();
        run_cmd(3, 8'h00, 1'b1, 0, clocks);

        // random mix
        for (int i = 0; i < 30; i++) begin
            ql = 2 + int'($urandom_range(3));
            qtr_len = QW'(ql);
            d = 8'($urandom);
            a = 1'($urandom);
            sts = starts;
            run_cmd(2, 8'h00, 1'b1, 0, clocks);
            chk(starts == sts + 1, "R3 random start", starts - sts, 1);
            slave_ack = a;
            run_cmd(4, d, 1'b1, 0, clocks);
            chk(clocks == quarters(4) * eff_len(ql), "R2 random write duration",
                clocks, quarters(4) * eff_len(ql));
            chk(rhist[8:0] == {d, 1'b1}, "R5 random write bits", rhist[8:0], {d, 1'b1});
            chk(nack == a, "R6 random ack", nack, a);
            slave_byte = 8'($urandom);
            run_cmd(5, 8'h00, a, 0, clocks);
            chk(clocks == quarters(5) * eff_len(ql), "R2 random read duration",
                clocks, quarters(5) * eff_len(ql));
            chk(rd_data == slave_byte, "R7 random read", rd_data, slave_byte);
            chk(rhist[0] == a, "R8 random ack level", rhist[0], a);
            sps = stops;
            run_cmd(3, 8'h00, 1'b1, 0, clocks);
            chk(stops == sps + 1, "R4 random stop", stops - sps, 1);
        end
        report();
    end
endmodule